// File: doc/BRIEF.md
# SPI Command Stream Executor

This block is the sequencing core of an SPI master that is programmed only through a stream of 16-bit instructions. It pops one instruction at a time from an external command queue and acts on it. An instruction can shift a run of words over the SPI lines, drive the chip-select lines, load one of three internal settings (clock divider, mode bits, word length), publish a synchronisation tag or wait for a set number of SCLK periods. Transmit words are taken from an external transmit queue and received words are pushed into an external receive queue. Both queues sit outside the block. Each queue entry carries one SPI word of 1 to 32 bits.

Every instruction packs a 4-bit opcode in bits [15:12], a 4-bit selector in bits [11:8] and an 8-bit value in bits [7:0]. Software writes a short program into the queue. A typical program is: mode write, divider write, width write, chip-select assert, transfer, chip-select release, sync. Software then waits for the sync event and the tag that comes with it.

The controller has four states, and these are its transitions:
- IDLE: accepts instructions. A transfer instruction moves it to WLOAD and a sleep instruction moves it to SLEEP. Every other instruction completes in IDLE in the cycle it is accepted.
- WLOAD: waits until the next word can proceed. It stays there while a needed transmit word is missing or the receive queue is full, then loads the word and moves to SHIFT.
- SHIFT: clocks out 2×width half-periods. After the last one it goes back to WLOAD if words remain, and otherwise to IDLE.
- SLEEP: counts down SCLK half-periods and then returns to IDLE.

Top module: `spi_cmd_exec`

## Requirements
- R1: The block accepts an instruction (cmd_valid and cmd_ready both high at a clock edge) only in IDLE, one per cycle. Opcodes 5 to 15, a register write with selector above 2, and a miscellaneous instruction with selector other than 0 or 1 are all consumed without changing any output or setting.
- R2: Opcode 2 writes the value field into a setting chosen by the selector: 0 is the divider (reset 0), 1 is the mode bits (reset 0) and 2 is the word width (low 6 bits, legal 1 to 32, reset 8). A new setting applies from the next instruction onward.
- R3: SCLK rests at the CPOL level outside transfers. During a word each half-period lasts divider+1 clock cycles, so a word holds SCLK at the active level for width×(divider+1) cycles.
- R4: The mode bits are bit 0 CPHA, bit 1 CPOL, bit 2 three-wire and bit 3 SDO idle high. With CPHA=0, data is sampled on the leading SCLK edge and changed on the trailing edge. With CPHA=1 it is the reverse. Words go out and come in MSB first.
- R5: Opcode 0 shifts value+1 words. Selector bit 0 enables sending from the transmit queue and bit 1 enables storing into the receive queue. Each word pops exactly one transmit entry when sending is enabled and pushes exactly one right-aligned, zero-extended receive entry when storing is enabled.
- R6: When the current word is not sending, sdo holds the idle level given by mode bit 3. In three-wire mode, a transfer that stores but does not send drives sdo_oe low for its whole duration.
- R7: Opcode 1 drives cs_n with the value field XOR the active polarity flags. After reset cs_n is all ones.
- R8: Opcode 4 stores new polarity flags. They leave cs_n unchanged until the next opcode 1 instruction applies them.
- R9: Opcode 3 with selector 0 loads the value field into sync_id and raises sync_pulse for one cycle, in the cycle after the instruction is accepted.
- R10: Opcode 3 with selector 1 waits value+1 SCLK periods at the current divider, which is 2×(value+1)×(divider+1) clock cycles, before the next instruction is accepted.
- R11: While a needed transmit word is absent or rx_ready is low, a word does not start. SCLK stays idle, and the word goes out intact once the condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command queue not empty |
| cmd_data | input | 16 | Head instruction |
| cmd_ready | output | 1 | Pop strobe for the command queue (high in IDLE) |
| tx_valid | input | 1 | Transmit queue not empty |
| tx_data | input | DATA_W | Head transmit word, right-aligned |
| tx_ready | output | 1 | Pop strobe for the transmit queue |
| rx_ready | input | 1 | Receive queue has room |
| rx_valid | output | 1 | Push strobe for the receive queue |
| rx_data | output | DATA_W | Received word, right-aligned |
| sclk | output | 1 | SPI clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (low during a three-wire read) |
| sdi | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Chip-select lines |
| sync_id | output | 8 | Last published sync tag |
| sync_pulse | output | 1 | One-cycle sync event |

## Verification
A slave model on the SPI lines checks the main transfer path. It runs through all four CPOL/CPHA combinations, dividers from 0 to 4 and widths of 1, 5, 8, 12, 16 and 32 bits. The transmit and receive words are asymmetric, so a wrong edge, a bit-order swap or a width mask error each shows up in a different way. Counting active-SCLK cycles per word separates divider errors from phase errors. Directed runs cover the remaining behaviour:
- a multi-word transfer;
- a stalled transmit queue and a full receive queue;
- chip-select polarity applied late;
- back-to-back sync and sleep, timed to the cycle;
- invalid opcodes.

// File: rtl/spi_exec_pkg.sv
package spi_exec_pkg;

    localparam logic [3:0] OP_XFER  = 4'd0;
    localparam logic [3:0] OP_CSEL  = 4'd1;
    localparam logic [3:0] OP_WREG  = 4'd2;
    localparam logic [3:0] OP_MISC  = 4'd3;
    localparam logic [3:0] OP_CSINV = 4'd4;

    localparam logic [3:0] REG_DIV  = 4'd0;
    localparam logic [3:0] REG_MODE = 4'd1;
    localparam logic [3:0] REG_BPW  = 4'd2;

    localparam logic [3:0] MISC_SYNC  = 4'd0;
    localparam logic [3:0] MISC_SLEEP = 4'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WLOAD,
        ST_SHIFT,
        ST_SLEEP
    } state_e;

    // bit 3 .. bit 0 of the mode register
    typedef struct packed {
        logic sdo_hi;
        logic three_wire;
        logic cpol;
        logic cpha;
    } mode_t;

endpackage

// File: rtl/spi_exec_tick.sv
module spi_exec_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run || tick)   cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // R3: half-period of divider+1 cycles, so ticks are spaced apart unless divider is 0
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/spi_exec_shift.sv
module spi_exec_shift #(
    parameter int DATA_W = 32,
    parameter int BPW_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [BPW_W-1:0]  bpw,
    input  logic              shift_out,
    input  logic              sample_in,
    input  logic              sdi,
    output logic              sdo_bit,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sr_q;
    logic [DATA_W-1:0] rx_sr_q;
    logic [BPW_W-1:0]  shamt;

    assign shamt   = BPW_W'(DATA_W) - bpw;
    assign sdo_bit = tx_sr_q[DATA_W-1];
    assign rx_word = rx_sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr_q <= '0;
            rx_sr_q <= '0;
        end else if (load) begin
            tx_sr_q <= wr_en ? (tx_word << shamt) : '0;
            rx_sr_q <= '0;
        end else begin
            if (shift_out) tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
            if (sample_in) rx_sr_q <= {rx_sr_q[DATA_W-2:0], sdi};
        end
    end

endmodule

// File: rtl/spi_exec_cs.sv
module spi_exec_cs #(
    parameter int NUM_CS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_mask,
    input  logic              set_pol,
    input  logic [7:0]        arg,
    output logic [NUM_CS-1:0] cs_n
);
    logic [NUM_CS-1:0] mask_q;
    logic [NUM_CS-1:0] pol_pend_q;
    logic [NUM_CS-1:0] pol_act_q;

    assign cs_n = mask_q ^ pol_act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '1;
            pol_pend_q <= '0;
            pol_act_q  <= '0;
        end else begin
            if (set_pol) pol_pend_q <= arg[NUM_CS-1:0];
            if (set_mask) begin
                mask_q    <= arg[NUM_CS-1:0];
                pol_act_q <= pol_pend_q;
            end
        end
    end

    // R7 / R8: lines only move after a mask instruction; a polarity write alone leaves them
    a_r8_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !set_mask |=> $stable(cs_n));

endmodule

// File: rtl/spi_cmd_exec.sv
module spi_cmd_exec
    import spi_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CS = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [15:0]       cmd_data,
    output logic              cmd_ready,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi,
    output logic [NUM_CS-1:0] cs_n,
    output logic [7:0]        sync_id,
    output logic              sync_pulse
);
    localparam int BPW_W = $clog2(DATA_W + 1);
    localparam int PH_W  = BPW_W + 1;
    localparam logic [BPW_W-1:0] BPW_RST = BPW_W'(8);

    state_e            state_q, state_d;
    logic [DIV_W-1:0]  div_q;
    mode_t             mode_q;
    logic [BPW_W-1:0]  bpw_q;
    logic              wr_q, rd_q;
    logic [7:0]        words_q;
    logic [PH_W-1:0]   phase_q;
    logic [8:0]        sleep_q;
    logic [7:0]        sync_id_q;
    logic              sync_pulse_q;

    logic [3:0] op, sel;
    logic [7:0] val;
    logic       acc, go, tick, last_ph, run;
    logic       load, shift_out, sample_in, sdo_bit;
    logic       set_mask, set_pol;
    logic [DATA_W-1:0] rx_word;

    assign op  = cmd_data[15:12];
    assign sel = cmd_data[11:8];
    assign val = cmd_data[7:0];

    assign acc     = cmd_valid && (state_q == ST_IDLE);
    assign go      = (!wr_q || tx_valid) && (!rd_q || rx_ready);
    assign last_ph = (phase_q == ({1'b0, bpw_q} << 1) - PH_W'(1));
    assign run     = (state_q == ST_SHIFT) || (state_q == ST_SLEEP);

    spi_exec_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
    );

    spi_exec_shift #(.DATA_W(DATA_W), .BPW_W(BPW_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .wr_en(wr_q), .tx_word(tx_data),
        .bpw(bpw_q), .shift_out(shift_out), .sample_in(sample_in), .sdi(sdi),
        .sdo_bit(sdo_bit), .rx_word(rx_word)
    );

    spi_exec_cs #(.NUM_CS(NUM_CS)) u_cs (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .set_pol(set_pol),
        .arg(val), .cs_n(cs_n)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc && op == OP_XFER)                         state_d = ST_WLOAD;
                else if (acc && op == OP_MISC && sel == MISC_SLEEP) state_d = ST_SLEEP;
            end
            ST_WLOAD: if (go) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last_ph) state_d = (words_q == 8'd0) ? ST_IDLE : ST_WLOAD;
            ST_SLEEP: if (tick && sleep_q == 9'd0) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // settings and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q        <= '0;
            mode_q       <= '0;
            bpw_q        <= BPW_RST;
            wr_q         <= 1'b0;
            rd_q         <= 1'b0;
            words_q      <= '0;
            phase_q      <= '0;
            sleep_q      <= '0;
            sync_id_q    <= '0;
            sync_pulse_q <= 1'b0;
        end else begin
            sync_pulse_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (acc) begin
                    if (op == OP_XFER) begin
                        wr_q    <= sel[0];
                        rd_q    <= sel[1];
                        words_q <= val;
                    end else if (op == OP_WREG) begin
                        if (sel == REG_DIV)  div_q  <= DIV_W'(val);
                        if (sel == REG_MODE) mode_q <= mode_t'(val[3:0]);
                        if (sel == REG_BPW)  bpw_q  <= val[BPW_W-1:0];
                    end else if (op == OP_MISC) begin
                        if (sel == MISC_SYNC) begin
                            sync_id_q    <= val;
                            sync_pulse_q <= 1'b1;
                        end
                        if (sel == MISC_SLEEP) sleep_q <= {val, 1'b1};
                    end
                end
                ST_WLOAD: if (go) phase_q <= '0;
                ST_SHIFT: if (tick) begin
                    if (last_ph) begin
                        if (words_q != 8'd0) words_q <= words_q - 8'd1;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                ST_SLEEP: if (tick && sleep_q != 9'd0) sleep_q <= sleep_q - 9'd1;
            endcase
        end
    end

    // outputs and strobes
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        load       = (state_q == ST_WLOAD) && go;
        tx_ready   = load && wr_q;
        shift_out  = (state_q == ST_SHIFT) && tick && phase_q[0] && !last_ph;
        sample_in  = (state_q == ST_SHIFT) && tick && !phase_q[0];
        rx_valid   = (state_q == ST_SHIFT) && tick && last_ph && rd_q;
        rx_data    = rx_word;
        set_mask   = acc && (op == OP_CSEL);
        set_pol    = acc && (op == OP_CSINV);
        sclk       = mode_q.cpol ^ ((state_q == ST_SHIFT) && (phase_q[0] ^ mode_q.cpha));
        sdo        = ((state_q == ST_SHIFT) && wr_q) ? sdo_bit : mode_q.sdo_hi;
        sdo_oe     = !(mode_q.three_wire && rd_q && !wr_q &&
                       (state_q == ST_WLOAD || state_q == ST_SHIFT));
        sync_id    = sync_id_q;
        sync_pulse = sync_pulse_q;
    end

    // R9: published tag is the value field of the instruction accepted one cycle earlier
    a_r9_sync_tag: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (sync_id == $past(cmd_data[7:0]) && $past(cmd_valid && cmd_ready)));

    // R11: no transmit pop without a word present
    a_r11_tx_pop: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_valid);

    // R5: receive push only into a queue with room
    a_r5_rx_room: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_ready);

    // R1: no instruction is taken while a transfer or sleep runs
    a_r1_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !cmd_ready);

endmodule

// File: tb/spi_cmd_exec_bench.sv
`timescale 1ns/1ps
module spi_cmd_exec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid, cmd_ready, tx_valid, tx_ready, rx_valid;
    logic        rx_ready = 1'b1;
    logic [15:0] cmd_data;
    logic [31:0] tx_data, rx_data;
    logic        sclk, sdo, sdo_oe, sdi, sync_pulse;
    logic [7:0]  cs_n, sync_id;

    always #10 clk = ~clk;

    spi_cmd_exec u_spi_cmd_exec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi),
        .cs_n(cs_n), .sync_id(sync_id), .sync_pulse(sync_pulse)
    );

    int errors = 0;
    int checks = 0;

    // queues
    logic [15:0] cq [0:63];
    logic [31:0] tq [0:15];
    logic [31:0] rl [0:15];
    int cw = 0, cr = 0, tw = 0, tr = 0, rn = 0;

    assign cmd_valid = (cr < cw);
    assign cmd_data  = cq[cr % 64];
    assign tx_valid  = (tr < tw);
    assign tx_data   = tq[tr % 16];

    always @(posedge clk) begin
        if (cmd_valid && cmd_ready) cr <= cr + 1;
        if (tx_valid && tx_ready)   tr <= tr + 1;
        if (rx_valid) begin
            rl[rn % 16] <= rx_data;
            rn <= rn + 1;
        end
    end

    // slave model
    logic        s_cpol = 1'b0, s_cpha = 1'b0, slv_en = 1'b0, sdi_r = 1'b0;
    int          s_bpw = 8;
    logic [31:0] s_miso = '0, mosi_acc = '0;
    int          lead_n = 0, trail_n = 0, mosi_n = 0;
    assign sdi = sdi_r;

    function automatic logic miso_bit(int k);
        return s_miso[s_bpw - 1 - (k % s_bpw)];
    endfunction

    always @(sclk) begin
        if (slv_en) begin
            if (sclk !== s_cpol) begin
                lead_n++;
                if (s_cpha) sdi_r = miso_bit(lead_n - 1);
                else begin mosi_acc = {mosi_acc[30:0], sdo}; mosi_n++; end
            end else begin
                trail_n++;
                if (s_cpha) begin mosi_acc = {mosi_acc[30:0], sdo}; mosi_n++; end
                else sdi_r = miso_bit(trail_n);
            end
        end
    end

    // monitors
    int cyc = 0, act_cnt = 0, sp_cnt = 0, sp_last = 0, sp_prev = 0, oe_low = 0, sdo_low_busy = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (slv_en && sclk !== s_cpol) act_cnt <= act_cnt + 1;
        if (sync_pulse) begin sp_cnt <= sp_cnt + 1; sp_prev <= sp_last; sp_last <= cyc; end
        if (!sdo_oe) oe_low <= oe_low + 1;
        if (!cmd_ready && sdo === 1'b0) sdo_low_busy <= sdo_low_busy + 1;
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [3:0] a1, input logic [7:0] a2);
        return {op, a1, a2};
    endfunction

    task automatic push_cmd(input logic [15:0] c);
        cq[cw % 64] = c;
        cw++;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!(cr == cw && cmd_ready));
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] wmask(input int b);
        return (b >= 32) ? 32'hFFFF_FFFF : ((32'd1 << b) - 32'd1);
    endfunction

    task automatic slave_start(input logic [3:0] mode, input int bpw, input logic [31:0] miso);
        s_cpol = mode[1]; s_cpha = mode[0]; s_bpw = bpw; s_miso = miso;
        lead_n = 0; trail_n = 0; mosi_n = 0; mosi_acc = '0;
        sdi_r = s_cpha ? 1'b0 : miso_bit(0);
        slv_en = 1'b1;
    endtask

    task automatic set_regs(input logic [3:0] mode, input logic [7:0] div, input logic [7:0] bpw);
        push_cmd(ins(4'd2, 4'd1, {4'd0, mode}));
        push_cmd(ins(4'd2, 4'd0, div));
        push_cmd(ins(4'd2, 4'd2, bpw));
        wait_done();
    endtask

    typedef struct packed {
        logic [3:0]  mode;
        logic [7:0]  div;
        logic [7:0]  bpw;
        logic [31:0] mosi;
        logic [31:0] miso;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 8'd1, 8'd8,  32'h0000_00A5, 32'h0000_003C},
        '{4'd1, 8'd2, 8'd8,  32'h0000_005A, 32'h0000_00C3},
        '{4'd2, 8'd0, 8'd16, 32'h0000_1234, 32'h0000_BEEF},
        '{4'd3, 8'd3, 8'd12, 32'h0000_0ABC, 32'h0000_05A3},
        '{4'd0, 8'd0, 8'd32, 32'hDEAD_BEEF, 32'h0F1E_2D3C},
        '{4'd3, 8'd1, 8'd1,  32'h0000_0001, 32'h0000_0001},
        '{4'd1, 8'd4, 8'd5,  32'h0000_0015, 32'h0000_000A}
    };

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset cs_n", cs_n, 8'hFF);
        chk("R3 reset sclk idle", sclk, 1'b0);
        chk("R9 reset sync_id", sync_id, 8'h00);
        chk("R6 reset sdo idle low / oe", {sdo, sdo_oe}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", cmd_ready, 1'b1);

        // table of mode/divider/width vectors (R2 R3 R4 R5)
        for (int i = 0; i < NV; i++) begin
            int a0, r0;
            set_regs(VECS[i].mode, VECS[i].div, VECS[i].bpw);
            slave_start(VECS[i].mode, int'(VECS[i].bpw), VECS[i].miso);
            a0 = act_cnt; r0 = rn;
            tq[tw % 16] = VECS[i].mosi; tw++;
            push_cmd(ins(4'd1, 4'd0, 8'hFE));
            push_cmd(ins(4'd0, 4'd3, 8'd0));
            push_cmd(ins(4'd1, 4'd0, 8'hFF));
            wait_done();
            slv_en = 1'b0;
            chk($sformatf("R4 vec%0d received word", i), rl[r0 % 16], VECS[i].miso & wmask(int'(VECS[i].bpw)));
            chk($sformatf("R4 vec%0d sent word", i), mosi_acc & wmask(int'(VECS[i].bpw)),
                VECS[i].mosi & wmask(int'(VECS[i].bpw)));
            chk($sformatf("R3 vec%0d active sclk cycles", i), act_cnt - a0,
                int'(VECS[i].bpw) * (int'(VECS[i].div) + 1));
            chk($sformatf("R5 vec%0d one push", i), rn - r0, 1);
        end

        // R5: multi-word read-only transfer, 3 words
        begin
            int r0;
            set_regs(4'd0, 8'd0, 8'd8);
            slave_start(4'd0, 8, 32'h96);
            r0 = rn;
            push_cmd(ins(4'd0, 4'd2, 8'd2));
            wait_done();
            slv_en = 1'b0;
            chk("R5 three words pushed", rn - r0, 3);
            chk("R5 third word", rl[(r0 + 2) % 16], 32'h96);
            chk("R5 no tx pop on read-only", tr, tw);
        end

        // R11: transmit stall between words
        begin
            set_regs(4'd0, 8'd1, 8'd8);
            slave_start(4'd0, 8, 32'h0);
            tq[tw % 16] = 32'h3C; tw++;
            push_cmd(ins(4'd0, 4'd1, 8'd1));
            repeat (60) @(negedge clk);
            chk("R11 stalled after first word bits", mosi_n, 8);
            chk("R11 sclk idle while stalled", sclk, 1'b0);
            chk("R11 busy while stalled", cmd_ready, 1'b0);
            tq[tw % 16] = 32'hC5; tw++;
            wait_done();
            slv_en = 1'b0;
            chk("R11 both words intact", mosi_acc[15:0], 16'h3CC5);
        end

        // R11: receive-full stall
        begin
            int r0, a0;
            slave_start(4'd0, 8, 32'h6B);
            r0 = rn; a0 = act_cnt;
            rx_ready = 1'b0;
            push_cmd(ins(4'd0, 4'd2, 8'd0));
            repeat (40) @(negedge clk);
            chk("R11 no sclk while rx full", act_cnt - a0, 0);
            chk("R11 no push while rx full", rn - r0, 0);
            rx_ready = 1'b1;
            wait_done();
            slv_en = 1'b0;
            chk("R11 word after rx stall", rl[r0 % 16], 32'h6B);
        end

        // R6: sdo idle high during read-only transfer; three-wire releases sdo
        begin
            int b0, o0;
            set_regs(4'd8, 8'd0, 8'd8);
            chk("R6 idle high sdo", sdo, 1'b1);
            b0 = sdo_low_busy;
            push_cmd(ins(4'd0, 4'd2, 8'd0));
            wait_done();
            chk("R6 sdo held high during read", sdo_low_busy - b0, 0);
            set_regs(4'd4, 8'd0, 8'd8);
            o0 = oe_low;
            push_cmd(ins(4'd0, 4'd2, 8'd0));
            wait_done();
            chk("R6 three-wire oe low cycles", (oe_low - o0) > 0, 1);
            set_regs(4'd0, 8'd0, 8'd8);
            o0 = oe_low;
            push_cmd(ins(4'd0, 4'd2, 8'd0));
            wait_done();
            chk("R6 four-wire keeps oe", oe_low - o0, 0);
        end

        // R7 R8: chip-select mask and late polarity
        push_cmd(ins(4'd1, 4'd0, 8'hF5)); wait_done();
        chk("R7 mask applied", cs_n, 8'hF5);
        push_cmd(ins(4'd4, 4'd0, 8'h81)); wait_done();
        chk("R8 polarity not yet applied", cs_n, 8'hF5);
        push_cmd(ins(4'd1, 4'd0, 8'hFF)); wait_done();
        chk("R8 polarity applied at assert", cs_n, 8'h7E);
        push_cmd(ins(4'd4, 4'd0, 8'h00));
        push_cmd(ins(4'd1, 4'd0, 8'hFF)); wait_done();
        chk("R7 release", cs_n, 8'hFF);

        // R9 R10: sync and sleep timing
        begin
            int s0;
            set_regs(4'd0, 8'd1, 8'd8);
            s0 = sp_cnt;
            push_cmd(ins(4'd3, 4'd0, 8'h42));
            push_cmd(ins(4'd3, 4'd1, 8'd2));
            push_cmd(ins(4'd3, 4'd0, 8'h77));
            wait_done();
            chk("R9 two sync pulses", sp_cnt - s0, 2);
            chk("R9 latest tag", sync_id, 8'h77);
            chk("R10 sleep 3 periods div1 gap", sp_last - sp_prev, 2 * 3 * 2 + 2);
            set_regs(4'd0, 8'd0, 8'd8);
            push_cmd(ins(4'd3, 4'd0, 8'h10));
            push_cmd(ins(4'd3, 4'd1, 8'd0));
            push_cmd(ins(4'd3, 4'd0, 8'h11));
            wait_done();
            chk("R10 sleep 1 period div0 gap", sp_last - sp_prev, 4);
        end

        // R1: ignored instructions
        begin
            int s0;
            s0 = sp_cnt;
            push_cmd(ins(4'd7, 4'd1, 8'h23));
            push_cmd(ins(4'd3, 4'd5, 8'h12));
            push_cmd(ins(4'd2, 4'd9, 8'h00));
            push_cmd(ins(4'd15, 4'd0, 8'h00));
            wait_done();
            chk("R1 ignored: cs_n", cs_n, 8'hFF);
            chk("R1 ignored: sync", {sync_id, 8'(sp_cnt - s0)}, {8'h11, 8'h00});
            chk("R1 ignored: sdo/sclk", {sdo, sclk}, 2'b00);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule